// File: doc/BRIEF.md
# Programmable Asynchronous Serial Framer

This block is the asynchronous transmit and receive datapath of a programmable serial port. On the transmit side it takes a byte from a parallel write port and sends it as a frame on a serial output. The frame is a low start bit, then the data bits least-significant first, then an optional parity bit, then one or two high stop bits. On the receive side it oversamples the serial input, rebuilds the character and presents it as a parallel byte with a ready flag. Start, parity and stop bits never appear on either parallel byte.

Character length (5, 6, 7 or 8 bits), parity enable, parity sense and stop-bit count come from static configuration inputs. Each engine captures these inputs when a frame begins. A shared 16x baud tick sets the bit timing. Separate enables gate each direction. A break control forces the serial output low. Sticky parity, overrun and framing flags stay set until an error-clear pulse clears them.

Top module: `async_framer`

## Requirements
- R1: `cfg_len` selects the character length as 5 + `cfg_len` bits (0 gives 5, 3 gives 8). Data is sent and received least-significant bit first. Bits of `rx_data` above the character length read as 0.
- R2: A transmitted frame is one low start bit, the data bits, a parity bit when `cfg_par_en` is 1, and one stop bit (two when `cfg_stop2` is 1) at high level. Each bit lasts 16 baud ticks, and the line idles high.
- R3: A write on `tx_wr` is accepted only while `tx_rdy` is 1. `tx_rdy` stays 0 from the accepted write until the byte moves into the shifter.
- R4: No frame starts while `tx_en` is 0. `txd` stays high and a pending byte is held until `tx_en` returns to 1.
- R5: While `brk` is 1, `txd` is 0 from the next clock on, whatever the data. When `brk` returns to 0, `txd` follows normal operation.
- R6: `rxd` is sampled at mid-bit. A low level that lasts less than half a bit time is rejected as a glitch and yields no character.
- R7: While `rx_en` is 0 no character is received and any frame in progress is dropped.
- R8: With parity enabled, a received parity bit that does not match the programmed sense sets `err_par`. Even parity (`cfg_par_odd` = 0) makes the count of ones over data and parity even.
- R9: A low first stop-bit sample sets `err_frm`. The character is still delivered.
- R10: A character that completes while `rx_valid` is 1 and not being read sets `err_ovr` and replaces `rx_data`. A pulse on `rx_rd` clears `rx_valid`.
- R11: The error flags are sticky. A pulse on `err_clr` clears all three together.
- R12: After reset `txd` is 1, `tx_rdy` is 1, `rx_valid` is 0 and all error flags are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| baud_tick | input | 1 | One-cycle pulse at 16x the bit rate |
| cfg_len | input | 2 | Character length code, 5 + value bits |
| cfg_par_en | input | 1 | Parity bit present |
| cfg_par_odd | input | 1 | 1 selects odd parity, 0 even |
| cfg_stop2 | input | 1 | Two transmit stop bits |
| tx_en | input | 1 | Transmit enable |
| rx_en | input | 1 | Receive enable |
| brk | input | 1 | Force serial output low |
| err_clr | input | 1 | Clear all error flags |
| tx_data | input | 8 | Byte to send |
| tx_wr | input | 1 | Write strobe for tx_data |
| tx_rdy | output | 1 | Transmit holding register empty |
| txd | output | 1 | Serial output |
| rxd | input | 1 | Serial input |
| rx_data | output | 8 | Received character, zero-filled |
| rx_valid | output | 1 | Received character ready |
| rx_rd | input | 1 | Acknowledge received character |
| err_par | output | 1 | Parity error flag |
| err_ovr | output | 1 | Overrun error flag |
| err_frm | output | 1 | Framing error flag |

## Verification
A wrong bit counter or a stale captured length shows up on the next loopback frame. It appears either as a character with the wrong value or stray upper bits, or as a false framing flag on the stop-bit sample, about 11 bit times after the write. A stuck transmit state keeps `txd` low or leaves `tx_rdy` at 0, and a direct waveform check at bit centres catches this within one frame. A receiver stuck outside its idle state drops the next injected character, and the error flags betray a clear or set path that misbehaves within two clocks of the pulse.

// File: rtl/framer_pkg.sv
package framer_pkg;

  // Shared bit-phase encoding for both shifters.
  typedef enum logic [2:0] {
    PH_IDLE  = 3'd0,
    PH_START = 3'd1,
    PH_DATA  = 3'd2,
    PH_PAR   = 3'd3,
    PH_STOP  = 3'd4
  } fr_phase_e;

endpackage

// File: rtl/framer_rst_sync.sv
module framer_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);

  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= {chain_q[STAGES-2:0], 1'b1};
  end

  assign rst_n_sync = chain_q[STAGES-1];

endmodule

// File: rtl/framer_tx.sv
module framer_tx
  import framer_pkg::*;
#(
  parameter int DATA_W   = 8,
  parameter int MIN_BITS = 5,
  parameter int OVS      = 16,
  localparam int LEN_W   = $clog2(DATA_W - MIN_BITS + 1),
  localparam int CNT_W   = $clog2(OVS),
  localparam int BIT_W   = $clog2(DATA_W)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  logic              tx_en,
  input  logic              brk,
  input  logic [LEN_W-1:0]  cfg_len,
  input  logic              cfg_par_en,
  input  logic              cfg_par_odd,
  input  logic              cfg_stop2,
  input  logic [DATA_W-1:0] tx_data,
  input  logic              tx_wr,
  output logic              tx_rdy,
  output logic              txd
);

  fr_phase_e          ph_q, ph_n;
  logic [CNT_W-1:0]   cnt_q, cnt_n;
  logic [BIT_W-1:0]   idx_q, idx_n;
  logic [DATA_W-1:0]  sh_q, sh_n;
  logic [DATA_W-1:0]  hold_q, hold_n;
  logic               hv_q, hv_n;
  logic               par_q, par_n;
  logic               stp_q, stp_n;
  logic [LEN_W-1:0]   len_q, len_n;
  logic               pen_q, pen_n;
  logic               s2_q, s2_n;
  logic               txd_q, txd_n;
  logic               bit_end;
  logic               line_lvl;
  logic [BIT_W-1:0]   last_idx;

  assign bit_end  = tick && (cnt_q == CNT_W'(OVS - 1));
  assign last_idx = BIT_W'(MIN_BITS - 1) + BIT_W'(len_q);

  always_comb begin
    ph_n   = ph_q;
    cnt_n  = cnt_q;
    idx_n  = idx_q;
    sh_n   = sh_q;
    hold_n = hold_q;
    hv_n   = hv_q;
    par_n  = par_q;
    stp_n  = stp_q;
    len_n  = len_q;
    pen_n  = pen_q;
    s2_n   = s2_q;

    if (tx_wr && !hv_q) begin
      hold_n = tx_data;
      hv_n   = 1'b1;
    end

    if (ph_q == PH_IDLE) begin
      if (tx_en && hv_q) begin
        sh_n  = hold_q;
        hv_n  = 1'b0;
        ph_n  = PH_START;
        cnt_n = '0;
        idx_n = '0;
        stp_n = 1'b0;
        par_n = cfg_par_odd;
        len_n = cfg_len;
        pen_n = cfg_par_en;
        s2_n  = cfg_stop2;
      end
    end else begin
      if (tick) cnt_n = bit_end ? '0 : cnt_q + CNT_W'(1);
      if (bit_end) begin
        unique case (ph_q)
          PH_START: ph_n = PH_DATA;
          PH_DATA: begin
            par_n = par_q ^ sh_q[0];
            sh_n  = sh_q >> 1;
            if (idx_q == last_idx) ph_n = pen_q ? PH_PAR : PH_STOP;
            else                   idx_n = idx_q + BIT_W'(1);
          end
          PH_PAR:  ph_n = PH_STOP;
          PH_STOP: begin
            if (s2_q && !stp_q) stp_n = 1'b1;
            else                ph_n  = PH_IDLE;
          end
          default: ph_n = PH_IDLE;
        endcase
      end
    end
  end

  always_comb begin
    unique case (ph_q)
      PH_START: line_lvl = 1'b0;
      PH_DATA:  line_lvl = sh_q[0];
      PH_PAR:   line_lvl = par_q;
      default:  line_lvl = 1'b1;
    endcase
    txd_n = brk ? 1'b0 : line_lvl;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph_q   <= PH_IDLE;
      cnt_q  <= '0;
      idx_q  <= '0;
      sh_q   <= '0;
      hold_q <= '0;
      hv_q   <= 1'b0;
      par_q  <= 1'b0;
      stp_q  <= 1'b0;
      len_q  <= '0;
      pen_q  <= 1'b0;
      s2_q   <= 1'b0;
      txd_q  <= 1'b1;
    end else begin
      ph_q   <= ph_n;
      cnt_q  <= cnt_n;
      idx_q  <= idx_n;
      sh_q   <= sh_n;
      hold_q <= hold_n;
      hv_q   <= hv_n;
      par_q  <= par_n;
      stp_q  <= stp_n;
      len_q  <= len_n;
      pen_q  <= pen_n;
      s2_q   <= s2_n;
      txd_q  <= txd_n;
    end
  end

  assign tx_rdy = !hv_q;
  assign txd    = txd_q;

  // R5: break drives the line low one clock later.
  p_brk_low_r5: assert property (@(posedge clk) disable iff (!rst_n)
    brk |=> !txd);

  // R4: an idle shifter keeps the line high unless break is asserted.
  p_idle_high_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (ph_q == PH_IDLE && !brk) |=> txd);

  // R3: a held byte cannot drain while transmit is disabled.
  p_hold_kept_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!tx_rdy && !tx_en) |=> !tx_rdy);

endmodule

// File: rtl/framer_rx.sv
module framer_rx
  import framer_pkg::*;
#(
  parameter int DATA_W      = 8,
  parameter int MIN_BITS    = 5,
  parameter int OVS         = 16,
  parameter int SYNC_STAGES = 2,
  localparam int LEN_W      = $clog2(DATA_W - MIN_BITS + 1),
  localparam int CNT_W      = $clog2(OVS),
  localparam int BIT_W      = $clog2(DATA_W)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  logic              rx_en,
  input  logic [LEN_W-1:0]  cfg_len,
  input  logic              cfg_par_en,
  input  logic              cfg_par_odd,
  input  logic              rxd,
  input  logic              rx_rd,
  output logic [DATA_W-1:0] rx_data,
  output logic              rx_valid,
  output logic              set_par,
  output logic              set_ovr,
  output logic              set_frm
);

  logic [SYNC_STAGES-1:0] sync_q;
  logic                   rx_s;
  fr_phase_e              ph_q, ph_n;
  logic [CNT_W-1:0]       cnt_q, cnt_n;
  logic [BIT_W-1:0]       idx_q, idx_n;
  logic [DATA_W-1:0]      sh_q, sh_n;
  logic                   par_q, par_n;
  logic                   perr_q, perr_n;
  logic [LEN_W-1:0]       len_q, len_n;
  logic                   pen_q, pen_n;
  logic [DATA_W-1:0]      data_q, data_n;
  logic                   vld_q, vld_n;
  logic                   done;
  logic                   bit_end;
  logic                   half_pt;
  logic [BIT_W-1:0]       last_idx;
  logic [BIT_W-1:0]       align_sh;

  assign rx_s     = sync_q[SYNC_STAGES-1];
  assign bit_end  = tick && (cnt_q == CNT_W'(OVS - 1));
  assign half_pt  = tick && (cnt_q == CNT_W'(OVS / 2 - 1));
  assign last_idx = BIT_W'(MIN_BITS - 1) + BIT_W'(len_q);
  assign align_sh = BIT_W'(DATA_W - MIN_BITS) - BIT_W'(len_q);

  always_comb begin
    ph_n    = ph_q;
    cnt_n   = cnt_q;
    idx_n   = idx_q;
    sh_n    = sh_q;
    par_n   = par_q;
    perr_n  = perr_q;
    len_n   = len_q;
    pen_n   = pen_q;
    data_n  = data_q;
    vld_n   = vld_q;
    done    = 1'b0;
    set_par = 1'b0;
    set_ovr = 1'b0;
    set_frm = 1'b0;

    if (rx_rd) vld_n = 1'b0;

    if (!rx_en) begin
      ph_n = PH_IDLE;
    end else begin
      unique case (ph_q)
        PH_IDLE: begin
          if (tick && !rx_s) begin
            ph_n   = PH_START;
            cnt_n  = '0;
            perr_n = 1'b0;
            par_n  = cfg_par_odd;
            len_n  = cfg_len;
            pen_n  = cfg_par_en;
          end
        end
        PH_START: begin
          if (half_pt) begin
            cnt_n = '0;
            idx_n = '0;
            ph_n  = rx_s ? PH_IDLE : PH_DATA;
          end else if (tick) begin
            cnt_n = cnt_q + CNT_W'(1);
          end
        end
        default: begin
          if (tick) cnt_n = bit_end ? '0 : cnt_q + CNT_W'(1);
          if (bit_end) begin
            if (ph_q == PH_DATA) begin
              sh_n  = {rx_s, sh_q[DATA_W-1:1]};
              par_n = par_q ^ rx_s;
              if (idx_q == last_idx) ph_n = pen_q ? PH_PAR : PH_STOP;
              else                   idx_n = idx_q + BIT_W'(1);
            end else if (ph_q == PH_PAR) begin
              perr_n = rx_s ^ par_q;
              ph_n   = PH_STOP;
            end else begin
              done    = 1'b1;
              ph_n    = PH_IDLE;
              data_n  = sh_q >> align_sh;
              vld_n   = 1'b1;
              set_frm = !rx_s;
              set_par = pen_q && perr_q;
              set_ovr = vld_q && !rx_rd;
            end
          end
        end
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= '1;
      ph_q   <= PH_IDLE;
      cnt_q  <= '0;
      idx_q  <= '0;
      sh_q   <= '0;
      par_q  <= 1'b0;
      perr_q <= 1'b0;
      len_q  <= '0;
      pen_q  <= 1'b0;
      data_q <= '0;
      vld_q  <= 1'b0;
    end else begin
      sync_q <= {sync_q[SYNC_STAGES-2:0], rxd};
      ph_q   <= ph_n;
      cnt_q  <= cnt_n;
      idx_q  <= idx_n;
      sh_q   <= sh_n;
      par_q  <= par_n;
      perr_q <= perr_n;
      len_q  <= len_n;
      pen_q  <= pen_n;
      data_q <= data_n;
      vld_q  <= vld_n;
    end
  end

  assign rx_data  = data_q;
  assign rx_valid = vld_q;

  // R1: bits above the captured length are zero when a character lands.
  p_zero_fill_r1: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> ((rx_data >> (MIN_BITS + int'(len_q))) == '0));

  // R7: no character completes in the cycle after receive is disabled.
  p_rx_gate_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !rx_en |=> !done);

  // R10: a read without a new arrival empties the receive register.
  p_read_clears_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_rd && !done) |=> !rx_valid);

endmodule

// File: rtl/framer_err.sv
module framer_err (
  input  logic clk,
  input  logic rst_n,
  input  logic set_par,
  input  logic set_ovr,
  input  logic set_frm,
  input  logic clr,
  output logic err_par,
  output logic err_ovr,
  output logic err_frm
);

  logic [2:0] flg_q, flg_n;
  logic [2:0] set_v;

  assign set_v = {set_par, set_ovr, set_frm};

  always_comb begin
    flg_n = clr ? set_v : (flg_q | set_v);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) flg_q <= '0;
    else        flg_q <= flg_n;
  end

  assign err_par = flg_q[2];
  assign err_ovr = flg_q[1];
  assign err_frm = flg_q[0];

  // R11: a clear with nothing arriving empties every flag.
  p_clear_all_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (clr && set_v == 3'b000) |=> (!err_par && !err_ovr && !err_frm));

  // R9: a framing flag persists until a clear.
  p_frm_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (err_frm && !clr) |=> err_frm);

endmodule

// File: rtl/async_framer.sv
module async_framer #(
  parameter int DATA_W      = 8,
  parameter int MIN_BITS    = 5,
  parameter int OVS         = 16,
  parameter int SYNC_STAGES = 2,
  parameter int RST_STAGES  = 2,
  localparam int LEN_W      = $clog2(DATA_W - MIN_BITS + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              baud_tick,
  input  logic [LEN_W-1:0]  cfg_len,
  input  logic              cfg_par_en,
  input  logic              cfg_par_odd,
  input  logic              cfg_stop2,
  input  logic              tx_en,
  input  logic              rx_en,
  input  logic              brk,
  input  logic              err_clr,
  input  logic [DATA_W-1:0] tx_data,
  input  logic              tx_wr,
  output logic              tx_rdy,
  output logic              txd,
  input  logic              rxd,
  output logic [DATA_W-1:0] rx_data,
  output logic              rx_valid,
  input  logic              rx_rd,
  output logic              err_par,
  output logic              err_ovr,
  output logic              err_frm
);

  logic rst_n_i;
  logic set_par, set_ovr, set_frm;

  framer_rst_sync #(.STAGES(RST_STAGES)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_n_sync (rst_n_i)
  );

  framer_tx #(.DATA_W(DATA_W), .MIN_BITS(MIN_BITS), .OVS(OVS)) u_tx (
    .clk         (clk),
    .rst_n       (rst_n_i),
    .tick        (baud_tick),
    .tx_en       (tx_en),
    .brk         (brk),
    .cfg_len     (cfg_len),
    .cfg_par_en  (cfg_par_en),
    .cfg_par_odd (cfg_par_odd),
    .cfg_stop2   (cfg_stop2),
    .tx_data     (tx_data),
    .tx_wr       (tx_wr),
    .tx_rdy      (tx_rdy),
    .txd         (txd)
  );

  framer_rx #(.DATA_W(DATA_W), .MIN_BITS(MIN_BITS), .OVS(OVS),
              .SYNC_STAGES(SYNC_STAGES)) u_rx (
    .clk         (clk),
    .rst_n       (rst_n_i),
    .tick        (baud_tick),
    .rx_en       (rx_en),
    .cfg_len     (cfg_len),
    .cfg_par_en  (cfg_par_en),
    .cfg_par_odd (cfg_par_odd),
    .rxd         (rxd),
    .rx_rd       (rx_rd),
    .rx_data     (rx_data),
    .rx_valid    (rx_valid),
    .set_par     (set_par),
    .set_ovr     (set_ovr),
    .set_frm     (set_frm)
  );

  framer_err u_err (
    .clk     (clk),
    .rst_n   (rst_n_i),
    .set_par (set_par),
    .set_ovr (set_ovr),
    .set_frm (set_frm),
    .clr     (err_clr),
    .err_par (err_par),
    .err_ovr (err_ovr),
    .err_frm (err_frm)
  );

endmodule

// File: tb/async_framer_tb_top.sv
`timescale 1ns/1ps
module async_framer_tb_top;

  localparam int TICK_DIV = 4;
  localparam int BIT_CLKS = 16 * TICK_DIV;
  localparam int NVEC     = 8;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       baud_tick = 1'b0;
  logic [1:0] cfg_len = 2'd3;
  logic       cfg_par_en = 1'b0, cfg_par_odd = 1'b0, cfg_stop2 = 1'b0;
  logic       tx_en = 1'b0, rx_en = 1'b0, brk = 1'b0, err_clr = 1'b0;
  logic [7:0] tx_data = 8'h00;
  logic       tx_wr = 1'b0, rx_rd = 1'b0;
  logic       tx_rdy, txd, rx_valid, err_par, err_ovr, err_frm;
  logic [7:0] rx_data;
  logic       lb = 1'b0;
  logic       rxd_drv = 1'b1;
  logic       rxd;
  int         n_chk = 0, n_bad = 0, cyc = 0, tick_ph = 0;
  bit         finished = 1'b0;

  assign rxd = lb ? txd : rxd_drv;

  always #2.5 clk = ~clk;

  always @(negedge clk) begin
    tick_ph   = (tick_ph == TICK_DIV - 1) ? 0 : tick_ph + 1;
    baud_tick = (tick_ph == 0);
  end

  async_framer dut_i (
    .clk(clk), .rst_n(rst_n), .baud_tick(baud_tick), .cfg_len(cfg_len),
    .cfg_par_en(cfg_par_en), .cfg_par_odd(cfg_par_odd), .cfg_stop2(cfg_stop2),
    .tx_en(tx_en), .rx_en(rx_en), .brk(brk), .err_clr(err_clr),
    .tx_data(tx_data), .tx_wr(tx_wr), .tx_rdy(tx_rdy), .txd(txd), .rxd(rxd),
    .rx_data(rx_data), .rx_valid(rx_valid), .rx_rd(rx_rd),
    .err_par(err_par), .err_ovr(err_ovr), .err_frm(err_frm)
  );

  // {len[1:0], par_en, par_odd, stop2, data[7:0]}
  localparam logic [12:0] VEC [NVEC] = '{
    {2'd3, 1'b0, 1'b0, 1'b0, 8'hA5},
    {2'd0, 1'b0, 1'b0, 1'b0, 8'hFF},
    {2'd1, 1'b1, 1'b0, 1'b0, 8'hC6},
    {2'd2, 1'b1, 1'b1, 1'b1, 8'h81},
    {2'd3, 1'b1, 1'b1, 1'b0, 8'h7E},
    {2'd3, 1'b0, 1'b0, 1'b1, 8'h00},
    {2'd0, 1'b1, 1'b1, 1'b1, 8'h15},
    {2'd2, 1'b0, 1'b0, 1'b1, 8'hFF}
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic clks(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic write_byte(input logic [7:0] d);
    @(negedge clk);
    tx_data = d;
    tx_wr   = 1'b1;
    @(negedge clk);
    tx_wr   = 1'b0;
  endtask

  task automatic read_ack();
    @(negedge clk);
    rx_rd = 1'b1;
    @(negedge clk);
    rx_rd = 1'b0;
  endtask

  task automatic wait_valid(input int lim);
    for (int i = 0; i < lim; i++) begin
      if (rx_valid) break;
      @(negedge clk);
    end
  endtask

  task automatic rx_bit(input logic b);
    rxd_drv = b;
    clks(BIT_CLKS);
  endtask

  task automatic send_frame(input logic [7:0] d, input int nb, input bit pe,
                            input bit pb, input bit sb);
    rx_bit(1'b0);
    for (int i = 0; i < nb; i++) rx_bit(d[i]);
    if (pe) rx_bit(pb);
    rx_bit(sb);
    rxd_drv = 1'b1;
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000 && !finished) begin
      n_bad++;
      $display("FAIL watchdog: actual %0d cycles expected completion", cyc);
      finish_run();
    end
  end

  initial begin
    logic [7:0] exp_d;
    logic [7:0] mask;
    int lows;

    clks(5);
    rst_n = 1'b1;
    clks(4);
    // R12: reset values
    chk("R12 txd", txd, 1);
    chk("R12 tx_rdy", tx_rdy, 1);
    chk("R12 rx_valid", rx_valid, 0);
    chk("R12 errors", {err_par, err_ovr, err_frm}, 0);

    // Vector loop: loopback through both engines (R1, R2, R8)
    lb = 1'b1; tx_en = 1'b1; rx_en = 1'b1;
    for (int v = 0; v < NVEC; v++) begin
      cfg_len     = VEC[v][12:11];
      cfg_par_en  = VEC[v][10];
      cfg_par_odd = VEC[v][9];
      cfg_stop2   = VEC[v][8];
      mask  = 8'((9'd1 << (5 + cfg_len)) - 9'd1);
      exp_d = VEC[v][7:0] & mask;
      write_byte(VEC[v][7:0]);
      wait_valid(3000);
      chk("R1 loopback data", rx_data, exp_d);
      chk("R2 loopback clean frame", {err_par, err_ovr, err_frm}, 0);
      read_ack();
      clks(3 * BIT_CLKS);
      chk("R3 tx_rdy back", tx_rdy, 1);
    end

    // R2: direct waveform at bit centres, 8 bits, no parity, one stop
    lb = 1'b0; cfg_len = 2'd3; cfg_par_en = 1'b0; cfg_stop2 = 1'b0;
    write_byte(8'hA5);
    for (int i = 0; i < 200; i++) begin
      if (!txd) break;
      @(negedge clk);
    end
    clks(BIT_CLKS / 2);
    chk("R2 start bit", txd, 0);
    for (int i = 0; i < 8; i++) begin
      clks(BIT_CLKS);
      chk("R2 data bit lsb first", txd, (8'hA5 >> i) & 1);
    end
    clks(BIT_CLKS);
    chk("R2 stop bit", txd, 1);
    clks(2 * BIT_CLKS);

    // R3/R4: write with transmit disabled
    tx_en = 1'b0;
    write_byte(8'h3C);
    chk("R3 tx_rdy low after write", tx_rdy, 0);
    lows = 0;
    for (int i = 0; i < 800; i++) begin
      @(negedge clk);
      if (!txd) lows++;
    end
    chk("R4 line idle while disabled", lows, 0);
    chk("R4 byte still held", tx_rdy, 0);
    lb = 1'b1; tx_en = 1'b1;
    wait_valid(3000);
    chk("R4 held byte sent on enable", rx_data, 8'h3C);
    read_ack();
    clks(2 * BIT_CLKS);

    // R5: break
    lb = 1'b0;
    brk = 1'b1;
    clks(2);
    chk("R5 break forces low", txd, 0);
    brk = 1'b0;
    clks(2);
    chk("R5 normal after break", txd, 1);

    // R7: receive disabled
    rx_en = 1'b0;
    send_frame(8'h5A, 8, 0, 0, 1);
    clks(10);
    chk("R7 no char while disabled", rx_valid, 0);
    rx_en = 1'b1;
    clks(4);

    // R6: glitch rejection then mid-bit sampling
    rxd_drv = 1'b0;
    clks(4 * TICK_DIV);
    rxd_drv = 1'b1;
    clks(20 * BIT_CLKS);
    chk("R6 glitch yields no char", rx_valid, 0);
    chk("R6 glitch no framing flag", err_frm, 0);
    send_frame(8'h96, 8, 0, 0, 1);
    chk("R6 mid-bit sampled char", rx_data, 8'h96);
    read_ack();

    // R8: parity error, even parity, 0x01 needs parity bit 1
    cfg_par_en = 1'b1; cfg_par_odd = 1'b0;
    send_frame(8'h01, 8, 1, 0, 1);
    chk("R8 parity flag", err_par, 1);
    chk("R8 char delivered", rx_data, 8'h01);
    read_ack();

    // R9: framing error
    cfg_par_en = 1'b0;
    send_frame(8'hC3, 8, 0, 0, 0);
    rx_en = 1'b0;
    clks(4);
    rx_en = 1'b1;
    chk("R9 framing flag", err_frm, 1);
    chk("R9 char still delivered", rx_valid, 1);
    read_ack();
    clks(2);
    chk("R10 read clears valid", rx_valid, 0);

    // R10: overrun
    send_frame(8'h11, 8, 0, 0, 1);
    send_frame(8'h22, 8, 0, 0, 1);
    chk("R10 overrun flag", err_ovr, 1);
    chk("R10 newest char kept", rx_data, 8'h22);
    read_ack();

    // R11: sticky then cleared together
    chk("R11 all flags sticky", {err_par, err_ovr, err_frm}, 3'b111);
    @(negedge clk);
    err_clr = 1'b1;
    @(negedge clk);
    err_clr = 1'b0;
    clks(2);
    chk("R11 flags cleared", {err_par, err_ovr, err_frm}, 3'b000);

    finish_run();
  end

endmodule